// File: doc/BRIEF.md
# DRAM Start-Up Command Sequencer

This block sits on the controller side of a low-latency DRAM and owns the command bus from reset until the memory is ready for normal traffic. After reset it waits for the clock-stable indication. It then drives a long stretch of no-operation commands whose length is set in microseconds and converted to cycles. Next it issues a run of mode-register-set commands on consecutive cycles. The first of these are dummies with the address bus held low. The last one carries the configured mode value. A short settling stretch of no-operations follows, and then the done flag rises.

The rest of the controller keeps the command bus muxed to this block while `init_done` is low. When the flag rises, it takes the bus over. If the clock-stable indication drops before the sequence completes, or reset is applied, the sequence starts again from the beginning. Once `init_done` is high, it stays high until the next reset.

Top module: `dram_boot_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is asserted, `cmd` is NOP, `addr` is all-zero and `init_done` is low.
- R2: After reset, while `clk_ok` has not been sampled high, `cmd` stays NOP, `addr` stays zero and `init_done` stays low.
- R3: The first clock edge that samples `clk_ok` high starts an idle stretch of exactly IDLE_US*CLK_MHZ cycles. During this stretch `cmd` is NOP and `addr` is zero.
- R4: Directly after the idle stretch, `cmd` is MRS on DUMMY_MRS back-to-back cycles, with `addr` all-zero on each. A DUMMY_MRS value below 2 is treated as 2.
- R5: On the very next cycle, `cmd` is MRS once more and `addr` equals `mode_val`. This makes at least three consecutive MRS cycles with no gap between them.
- R6: After the valid MRS, `cmd` is NOP for SETTLE_CYCLES cycles, and then `init_done` goes high. From then on, `init_done` stays high and `cmd` stays NOP, whatever `clk_ok` does, until reset.
- R7: If `clk_ok` is sampled low at any point between the start of the idle stretch and `init_done`, the block returns to waiting. It drives NOP with zero address, and the next high `clk_ok` restarts the full idle count.
- R8: Reset applied at any point during the sequence returns the block to the state of R1 and clears the idle count.
- R9: The `cmd` encoding is NOP=0, MRS=1, READ=2, WRITE=3, REFRESH=4. Only 0 and 1 ever appear on `cmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ok | input | 1 | High once supplies and clock are stable |
| mode_val | input | ADDR_W | Mode value placed on the address bus by the valid MRS |
| cmd | output | 3 | Command code (NOP=0, MRS=1, READ=2, WRITE=3, REFRESH=4) |
| addr | output | ADDR_W | Address bus to the memory |
| init_done | output | 1 | High once the start-up sequence has completed |

## Verification
A wrong state or counter value shows up at the ports within one cycle. The output may be an MRS that arrives one cycle early or late, a nonzero address on a dummy, or a gap between the MRS commands. It may also be `init_done` rising a cycle off, or NOP persisting after an abort where the count should have restarted. The bench compares every cycle against a cycle-indexed model. A miscount therefore fails at the first cycle where the phase boundary differs.

// File: rtl/dram_boot_seq.sv
module dram_boot_seq #(
  parameter int ADDR_W        = 18,
  parameter int IDLE_US       = 200,
  parameter int CLK_MHZ       = 400,
  parameter int DUMMY_MRS     = 2,
  parameter int SETTLE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_ok,
  input  logic [ADDR_W-1:0] mode_val,
  output logic [2:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam int IDLE_CYC = (IDLE_US * CLK_MHZ < 1) ? 1 : IDLE_US * CLK_MHZ;
  localparam int NDUM     = (DUMMY_MRS < 2) ? 2 : DUMMY_MRS;
  localparam int NSET     = (SETTLE_CYCLES < 1) ? 1 : SETTLE_CYCLES;
  localparam int MAXC     = (IDLE_CYC > NSET) ? ((IDLE_CYC > NDUM) ? IDLE_CYC : NDUM)
                                              : ((NSET > NDUM) ? NSET : NDUM);
  localparam int CW       = $clog2(MAXC + 1);

  localparam logic [2:0] C_NOP = 3'd0;
  localparam logic [2:0] C_MRS = 3'd1;
  localparam logic [2:0] C_RD  = 3'd2;
  localparam logic [2:0] C_WR  = 3'd3;
  localparam logic [2:0] C_REF = 3'd4;

  localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_CYC - 1);
  localparam logic [CW-1:0] DUM_LAST  = CW'(NDUM - 1);
  localparam logic [CW-1:0] SET_LAST  = CW'(NSET - 1);

  typedef enum logic [2:0] {S_WAIT, S_IDLE, S_DUM, S_MRS, S_SET, S_DONE} st_t;

  st_t           st, st_n;
  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    st_n  = st;
    cnt_n = cnt + 1'b1;
    case (st)
      S_WAIT: begin
        cnt_n = '0;
        if (clk_ok) st_n = S_IDLE;
      end
      S_IDLE: if (cnt == IDLE_LAST) begin st_n = S_DUM; cnt_n = '0; end
      S_DUM:  if (cnt == DUM_LAST)  begin st_n = S_MRS; cnt_n = '0; end
      S_MRS:  begin st_n = S_SET; cnt_n = '0; end
      S_SET:  if (cnt == SET_LAST)  begin st_n = S_DONE; cnt_n = '0; end
      S_DONE: cnt_n = cnt;
      default: begin st_n = S_WAIT; cnt_n = '0; end
    endcase
    if (st != S_WAIT && st != S_DONE && !clk_ok) begin
      st_n  = S_WAIT;
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_WAIT;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end

  assign cmd       = (st == S_DUM || st == S_MRS) ? C_MRS : C_NOP;
  assign addr      = (st == S_MRS) ? mode_val : '0;
  assign init_done = (st == S_DONE);

  assert_cmd_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd != C_RD && cmd != C_WR && cmd != C_REF);

  assert_idle_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> cnt <= IDLE_LAST);

  assert_first_mrs_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd == C_MRS) |-> addr == '0);

  assert_mrs_back_to_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DUM && clk_ok) |=> cmd == C_MRS);

  assert_done_after_settle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(st) == S_SET && $past(cmd) == C_NOP);

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done && cmd == C_NOP);

  assert_abort_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_ok && !init_done) |=> st == S_WAIT && cmd == C_NOP);

endmodule

// File: tb/sim_dram_boot_seq.sv
module sim_dram_boot_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 18;
  localparam int IDLE = 37;
  localparam int ND   = 3;
  localparam int NS   = 6;
  localparam int DONE_J = IDLE + ND + NS + 1;

  logic clk = 0, rst_n = 0, clk_ok = 0;
  logic [AW-1:0] mode_val = '0;
  logic [2:0] cmd;
  logic [AW-1:0] addr;
  logic init_done;

  int nchk = 0, nfail = 0, cyc = 0;
  bit started = 0, ev_abort = 0, ev_rst = 0, in_rst = 1, finished = 0;
  int j = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_boot_seq #(.ADDR_W(AW), .IDLE_US(1), .CLK_MHZ(IDLE), .DUMMY_MRS(ND),
                  .SETTLE_CYCLES(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_ok(clk_ok), .mode_val(mode_val),
    .cmd(cmd), .addr(addr), .init_done(init_done));

  function automatic logic [2:0] exp_cmd(bit s, int k);
    if (!s) return 3'd0;
    if (k >= IDLE && k <= IDLE + ND) return 3'd1;
    return 3'd0;
  endfunction

  function automatic logic [AW-1:0] exp_addr(bit s, int k, logic [AW-1:0] m);
    return (s && k == IDLE + ND) ? m : '0;
  endfunction

  function automatic logic exp_done(bit s, int k);
    return s && k >= DONE_J;
  endfunction

  function automatic string tag_of(bit s, int k);
    if (ev_rst) return "R8";
    if (in_rst) return "R1";
    if (ev_abort) return "R7";
    if (!s) return "R2";
    if (k < IDLE) return "R3";
    if (k < IDLE + ND) return "R4";
    if (k == IDLE + ND) return "R5";
    return "R6";
  endfunction

  task automatic check_now();
    string t;
    logic [2:0] ec;
    logic [AW-1:0] ea;
    logic ed;
    t  = tag_of(started, j);
    ec = exp_cmd(started, j);
    ea = exp_addr(started, j, mode_val);
    ed = exp_done(started, j);
    nchk++;
    if (cmd !== ec || addr !== ea || init_done !== ed) begin
      nfail++;
      $display("FAIL %s j=%0d: cmd=%0d addr=%h done=%b, expected cmd=%0d addr=%h done=%b",
               t, j, cmd, addr, init_done, ec, ea, ed);
    end
    nchk++;
    if (cmd > 3'd1) begin
      nfail++;
      $display("FAIL R9: cmd=%0d, expected 0 or 1", cmd);
    end
  endtask

  task automatic step(input logic r, input logic ok);
    rst_n    = r;
    clk_ok   = ok;
    mode_val = AW'($urandom);
    @(posedge clk);
    ev_abort = 0; ev_rst = 0; in_rst = 0;
    if (!r) begin
      ev_rst = started; in_rst = !started; started = 0; j = 0;
    end else if (!started) begin
      if (ok) begin started = 1; j = 0; end
    end else if (j >= DONE_J) begin
      j++;
    end else if (!ok) begin
      started = 0; j = 0; ev_abort = 1;
    end else begin
      j++;
    end
    @(negedge clk);
    check_now();
  endtask

  task automatic run(input int dly, input int abort_at, input int kind, input int tail);
    step(0, 0);
    step(0, 0);
    for (int c = 0; c < dly; c++) step(1, 0);
    for (int c = 0; c < abort_at; c++) step(1, 1);
    if (kind == 1) step(1, 0);
    if (kind == 2) step(0, 1);
    for (int c = 0; c < 200 && !(started && j >= DONE_J); c++) step(1, 1);
    for (int c = 0; c < tail; c++) step(1, 1'($urandom % 2));
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    check_now();
    run(4, 0, 0, 12);
    run(2, 10, 1, 3);
    run(0, IDLE + 1, 1, 3);
    run(1, IDLE + ND + 1, 1, 2);
    run(3, IDLE + ND + 3, 2, 4);
    run(0, 5, 2, 2);
    for (int r = 0; r < 25; r++)
      run(int'($urandom % 6), int'($urandom % DONE_J), int'($urandom % 3),
          int'($urandom % 8));
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles, expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule